// File: doc/BRIEF.md
# Prime-Modulus Memory Bank Mapper

This block converts a flat word address into a pair made of a bank index and a word position inside that bank. It is meant for an interleaved memory whose bank count is a Mersenne prime, 2^M − 1. Power-of-two strides are common in array walks. With a bank count that is not a power of two, such a stride spreads across all banks instead of hitting one bank over and over. The words per bank are a power of two, so the in-bank position is the low part of the address. The bank count and the words per bank then share no factor, and every address below their product gets a distinct pair.

The bank index needs no divider. Address bit k has residue 2^(k mod M) with respect to the prime, so each set bit adds a fixed power of two. The first pipeline stage adds up these per-bit residues. The second stage folds the sum back into M bits with end-around carry and maps the all-ones result to zero. A request is an address with a valid strobe. Its result appears two cycles later with its own valid strobe, and the block accepts one request every cycle.

Top module: `prime_bank_mapper`

## Requirements
- R1: For any address below (2^M − 1)·2^OFS_W, `out_bank` equals the address modulo 2^M − 1 (31 with the default M = 5).
- R2: `out_offset` equals the address modulo 2^OFS_W, which is the low OFS_W address bits (1024 words per bank by default).
- R3: A request sampled with `in_valid` high at a rising edge has its result, with `out_valid` high, after the second rising edge that follows it. After only the first of those edges `out_valid` is not yet high for it.
- R4: `out_valid` is high only for cycles that carry the result of an accepted request. A cycle with `in_valid` low gives a cycle with `out_valid` low two edges later.
- R5: `out_bank` never takes the all-ones value. An address that is a non-zero multiple of 2^M − 1 gives bank 0.
- R6: While `rst_n` is low, `out_valid`, `out_bank` and `out_offset` are all zero.
- R7: Requests on consecutive cycles give results on consecutive cycles, in the order they were issued.
- R8: With a stride equal to the words per bank, 2^M − 1 consecutive accesses starting at address 0 land in 2^M − 1 different banks.
- R9: A cycle with `in_valid` low does not disturb the outputs. `out_bank` and `out_offset` keep the last result while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The address on `in_addr` is a request this cycle |
| in_addr | input | ADDR_W | Word address, expected below (2^M − 1)·2^OFS_W |
| out_valid | output | 1 | `out_bank` and `out_offset` hold a fresh result |
| out_bank | output | M_BITS | Bank index, address modulo 2^M − 1 |
| out_offset | output | OFS_W | Word position inside the bank |

## Verification
The bench targets addresses whose per-bit residues add up to exactly the prime or one of its multiples. A design that skips the final all-ones correction would report bank 31 for these, and a design with too few folds would keep a carry in the result. Strides equal to the bank depth are walked across all banks. A mapper that used low address bits, or a broken residue table, would send them to repeated banks. Single requests, bubbles and back-to-back streams catch results that come one cycle early or late, valid strobes without a request, and outputs that change during idle cycles. The top of the address range checks that the sum width does not overflow.

// File: rtl/prime_bank_pkg.sv
package prime_bank_pkg;

    // residue of 2^k modulo (2^m - 1) is 2^(k mod m)
    function automatic int unsigned bit_residue(input int unsigned k, input int unsigned m);
        return 32'd1 << (k % m);
    endfunction

    // number of m-bit slices covering a w-bit address
    function automatic int unsigned slice_count(input int unsigned w, input int unsigned m);
        return (w + m - 1) / m;
    endfunction

endpackage

// File: rtl/prime_residue_sum.sv
module prime_residue_sum
    import prime_bank_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int M_BITS = 5,
    parameter int SUM_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SUM_W-1:0]  sum
);

    logic [SUM_W-1:0] term [ADDR_W];

    // each set address bit contributes its precomputed residue
    for (genvar k = 0; k < ADDR_W; k++) begin : g_term
        localparam logic [SUM_W-1:0] RES = SUM_W'(bit_residue(k, M_BITS));
        assign term[k] = addr[k] ? RES : '0;
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < ADDR_W; k++) begin
            sum = sum + term[k];
        end
    end

endmodule

// File: rtl/prime_eac_fold.sv
module prime_eac_fold #(
    parameter int SUM_W  = 8,
    parameter int M_BITS = 5
) (
    input  logic [SUM_W-1:0]  sum,
    output logic [M_BITS-1:0] bank,
    output logic              spill
);

    localparam int NFOLD = SUM_W / M_BITS + 2;

    logic [SUM_W-1:0] stage [NFOLD+1];
    logic [SUM_W-1:0] last;

    assign stage[0] = sum;

    // end-around carry: upper part is added back onto the low M bits
    for (genvar j = 0; j < NFOLD; j++) begin : g_fold
        assign stage[j+1] = SUM_W'(stage[j][M_BITS-1:0]) + (stage[j] >> M_BITS);
    end

    assign last  = stage[NFOLD];
    assign spill = |last[SUM_W-1:M_BITS];

    // all-ones is congruent to zero modulo 2^M - 1
    always_comb begin
        if (last[M_BITS-1:0] == {M_BITS{1'b1}}) begin
            bank = '0;
        end else begin
            bank = last[M_BITS-1:0];
        end
    end

endmodule

// File: rtl/prime_bank_mapper.sv
module prime_bank_mapper
    import prime_bank_pkg::*;
#(
    parameter int M_BITS = 5,
    parameter int OFS_W  = 10,
    parameter int ADDR_W = M_BITS + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic [M_BITS-1:0] out_bank,
    output logic [OFS_W-1:0]  out_offset
);

    localparam int NSLICE = slice_count(ADDR_W, M_BITS);
    localparam int SUM_W  = M_BITS + $clog2(NSLICE) + 1;

    typedef struct packed {
        logic             vld;
        logic [SUM_W-1:0] sum;
        logic [OFS_W-1:0] ofs;
    } sum_stage_t;

    typedef struct packed {
        logic              vld;
        logic [M_BITS-1:0] bank;
        logic [OFS_W-1:0]  ofs;
    } fold_stage_t;

    typedef struct packed {
        sum_stage_t  s1;
        fold_stage_t s2;
    } pipe_t;

    pipe_t            pipe_d, pipe_q;
    logic [SUM_W-1:0] sum_w;
    logic [M_BITS-1:0] bank_w;
    logic             spill_w;

    prime_residue_sum #(
        .ADDR_W (ADDR_W),
        .M_BITS (M_BITS),
        .SUM_W  (SUM_W)
    ) u_sum (
        .addr (in_addr),
        .sum  (sum_w)
    );

    prime_eac_fold #(
        .SUM_W  (SUM_W),
        .M_BITS (M_BITS)
    ) u_fold (
        .sum   (pipe_q.s1.sum),
        .bank  (bank_w),
        .spill (spill_w)
    );

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.s1.vld = in_valid;
        if (in_valid) begin
            pipe_d.s1.sum = sum_w;
            pipe_d.s1.ofs = in_addr[OFS_W-1:0];
        end
        pipe_d.s2.vld = pipe_q.s1.vld;
        if (pipe_q.s1.vld) begin
            pipe_d.s2.bank = bank_w;
            pipe_d.s2.ofs  = pipe_q.s1.ofs;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid  = pipe_q.s2.vld;
    assign out_bank   = pipe_q.s2.bank;
    assign out_offset = pipe_q.s2.ofs;

    // R4
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> pipe_q.s1.vld);

    // R4
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !pipe_q.s1.vld);

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.s1.vld |=> out_valid);

    // R2
    offset_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.s1.vld |=> (out_offset == $past(pipe_q.s1.ofs)));

    // R1
    fold_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.s1.vld |-> !spill_w);

    // R5
    bank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_bank != {M_BITS{1'b1}}));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_q.s1.vld |=> ($stable(out_bank) && $stable(out_offset)));

endmodule

// File: tb/sim_prime_bank_mapper.sv
module sim_prime_bank_mapper;

    localparam int M_BITS = 5;
    localparam int OFS_W  = 10;
    localparam int ADDR_W = M_BITS + OFS_W;
    localparam int NB     = (1 << M_BITS) - 1;
    localparam int WB     = 1 << OFS_W;
    localparam int NTAB   = 16;

    localparam int unsigned VEC [NTAB] = '{
        0, 1, 30, 31, 32, 62, 1023, 1024,
        2047, 4096, 8191, 31743, 12345, 21845, 31000, 21700
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic              out_valid;
    logic [M_BITS-1:0] out_bank;
    logic [OFS_W-1:0]  out_offset;

    int checks = 0;
    int fails  = 0;
    int obs [64];

    always #5 clk = ~clk;

    prime_bank_mapper #(
        .M_BITS (M_BITS),
        .OFS_W  (OFS_W),
        .ADDR_W (ADDR_W)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_addr    (in_addr),
        .out_valid  (out_valid),
        .out_bank   (out_bank),
        .out_offset (out_offset)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // drive a back-to-back stream, check each result two negedges later (R3, R7)
    task automatic run_stream(input int unsigned a[$]);
        int n = a.size();
        for (int i = 0; i < n + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                int unsigned x = a[i-2];
                obs[i-2] = int'(out_bank);
                chk(out_valid == 1'b1, "R7 stream valid", int'(out_valid), 1);
                if (x != 0 && x % NB == 0)
                    chk(out_bank == 0, "R5 multiple of prime", int'(out_bank), 0);
                else
                    chk(int'(out_bank) == int'(x % NB), "R1 bank", int'(out_bank), int'(x % NB));
                chk(int'(out_offset) == int'(x % WB), "R2 offset", int'(out_offset), int'(x % WB));
            end
            if (i < n) begin
                in_valid = 1'b1;
                in_addr  = ADDR_W'(a[i]);
            end else begin
                in_valid = 1'b0;
                in_addr  = '0;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R3 watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        int unsigned q[$];
        bit seen [NB];

        // R6: reset state
        in_addr = ADDR_W'(12345);
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R6 reset valid", int'(out_valid), 0);
        chk(out_bank == 0, "R6 reset bank", int'(out_bank), 0);
        chk(out_offset == 0, "R6 reset offset", int'(out_offset), 0);
        in_valid = 1'b0;
        in_addr  = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // table of vectors, back-to-back (R1, R2, R5, R7)
        q = {};
        for (int i = 0; i < NTAB; i++) q.push_back(VEC[i]);
        run_stream(q);

        // R3, R4: single request latency and empty cycles around it
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = ADDR_W'(1000);
        @(negedge clk);
        in_valid = 1'b0;
        in_addr  = ADDR_W'(77);
        chk(out_valid == 1'b0, "R3 not after one edge", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R3 valid after two edges", int'(out_valid), 1);
        chk(int'(out_bank) == 1000 % NB, "R3 bank", int'(out_bank), 1000 % NB);
        chk(int'(out_offset) == 1000 % WB, "R3 offset", int'(out_offset), 1000 % WB);
        @(negedge clk);
        chk(out_valid == 1'b0, "R4 bubble valid", int'(out_valid), 0);
        // R9: idle cycle with changing address leaves outputs alone
        chk(int'(out_bank) == 1000 % NB, "R9 bank held", int'(out_bank), 1000 % NB);
        chk(int'(out_offset) == 1000 % WB, "R9 offset held", int'(out_offset), 1000 % WB);
        in_addr = ADDR_W'(30000);
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R4 idle valid", int'(out_valid), 0);
        chk(int'(out_bank) == 1000 % NB, "R9 bank still held", int'(out_bank), 1000 % NB);

        // R8: stride equal to bank depth covers all banks
        q = {};
        for (int k = 0; k < NB; k++) q.push_back(k * WB);
        run_stream(q);
        for (int k = 0; k < NB; k++) seen[k] = 1'b0;
        for (int k = 0; k < NB; k++) begin
            chk(seen[obs[k]] == 1'b0, "R8 distinct bank", obs[k], k);
            seen[obs[k]] = 1'b1;
        end

        // R1: power-of-two strides of 32 and 64 words
        q = {};
        for (int k = 0; k < 40; k++) q.push_back(k * 64 + 3);
        for (int k = 0; k < 20; k++) q.push_back(k * 32);
        run_stream(q);

        // R1, R2: pseudo-random in-range addresses
        q = {};
        for (int k = 0; k < 60; k++) q.push_back($urandom % (NB * WB));
        run_stream(q);

        // R6: reset in the middle of traffic
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = ADDR_W'(555);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R6 mid reset valid", int'(out_valid), 0);
        chk(out_bank == 0, "R6 mid reset bank", int'(out_bank), 0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R4 no result after reset", int'(out_valid), 0);

        report();
        $finish;
    end

endmodule